// File: doc/BRIEF.md
# Call and Hardware Loop Stack Unit

This unit is the control-stack part of a program sequencer. A deep return-address stack receives the return address on every call and on every interrupt entry, and a return removes it again. Alongside it, two shallow stacks hold the state of zero-overhead loops. One holds the iteration counter and the other holds a tag made of the end address and the exit mode. When a loop is opened, its first instruction address is placed on the return stack, so that address is the target of every branch back to the loop start.

On every fetch, the unit compares the fetch address with the end address of the innermost loop. On a match it either reports a branch back to the loop start, decrementing the counter for a counted loop, or it reports the loop exit and removes the loop from all three stacks. A flag-controlled loop sees the condition flags as they stood two cycles before the test, which matches the pipeline spacing between setting a flag and testing it. When the return stack is close to full, the unit raises a warning interrupt request. Pushing onto a full stack or popping an empty one sets a sticky error flag that stays set until it is cleared.

The decode logic issues at most one command per cycle from call, return, open-loop and abandon-loop. The same commands serve software that pushes to or pops from the stacks. The top entries of the stacks and their depths are always visible on outputs.

Top module: `ctlstk_unit`

## Requirements
- R1: After reset both depths are 0, all four error flags are 0, stack_warn_irq is 0, jump_back and loop_exit are 0, and every top output reads 0.
- R2: call_req places call_addr on the return stack and ret_req removes the top entry, in last-in first-out order; ret_top shows the newest entry one cycle after the push.
- R3: The return stack holds 30 entries. A push while it is full changes nothing on the stack and sets ret_overflow. A pop while it is empty leaves the depth at 0 and sets ret_underflow.
- R4: stack_warn_irq is 1 exactly while ret_depth is 29 or more.
- R5: loop_req pushes loop_start onto the return stack, and pushes loop_count and the tag {loop_by_count, loop_flag_sel, loop_end} onto the loop stacks, all in one cycle. If the return stack is full it sets ret_overflow, and if the loop stacks are full it sets loop_overflow. In either case nothing is pushed.
- R6: The loop stacks hold 6 entries. loop_abort pops only the loop stacks and leaves the return stack as it was. loop_abort while they are empty sets loop_underflow.
- R7: When fetch_valid is 1, a loop is open, fetch_addr equals end_top, and the loop does not terminate, jump_back is 1 in that same cycle and jump_target equals ret_top. A counted loop (loop_by_count=1) shows cnt_top one lower on the next cycle. Both depths stay unchanged.
- R8: A counted loop terminates at its end address when cnt_top is 1 or 0. In that cycle loop_exit is 1 and jump_back is 0. On the next cycle the loop stacks and the return stack are each one entry shallower.
- R9: A flag loop (loop_by_count=0) terminates at its end address when bit loop_flag_sel of cond_flags was 1 two cycles before the test cycle. A flag that is set one cycle before the test, or only in the test cycle, does not count.
- R10: Each error flag stays set until clear_sticky. If a new error and clear_sticky occur in the same cycle, the flag ends up set.
- R11: In any cycle with jump_back or loop_exit, all four commands are ignored. Otherwise only the highest-priority request is served, in the order call_req, ret_req, loop_req, loop_abort.
- R12: end_top shows the end address of the innermost open loop. When an inner loop exits, end_top, cnt_top and ret_top show the enclosing loop again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_req | input | 1 | Push call_addr (call, interrupt entry or software push) |
| call_addr | input | 24 | Return address to push |
| ret_req | input | 1 | Pop the return stack |
| loop_req | input | 1 | Open a loop |
| loop_start | input | 24 | First instruction address of the loop |
| loop_end | input | 24 | Last instruction address of the loop |
| loop_count | input | 16 | Iteration count of a counted loop |
| loop_by_count | input | 1 | 1: counted loop, 0: flag loop |
| loop_flag_sel | input | 3 | Index of the exit flag in cond_flags |
| loop_abort | input | 1 | Pop the loop stacks only |
| fetch_valid | input | 1 | fetch_addr is valid this cycle |
| fetch_addr | input | 24 | Current fetch address |
| cond_flags | input | 8 | Condition flags |
| clear_sticky | input | 1 | Clear all error flags |
| jump_back | output | 1 | Next fetch goes to jump_target |
| jump_target | output | 24 | Loop start address |
| loop_exit | output | 1 | Innermost loop terminates at this fetch |
| ret_top | output | 24 | Top of the return stack (0 when empty) |
| ret_depth | output | 5 | Entries on the return stack |
| cnt_top | output | 16 | Top loop counter (0 when empty) |
| end_top | output | 24 | Top loop end address (0 when empty) |
| loop_depth | output | 3 | Entries on the loop stacks |
| stack_warn_irq | output | 1 | Return stack near full |
| ret_overflow | output | 1 | Sticky: push to full return stack |
| ret_underflow | output | 1 | Sticky: pop of empty return stack |
| loop_overflow | output | 1 | Sticky: loop opened with loop stacks full |
| loop_underflow | output | 1 | Sticky: loop stacks popped while empty |

## Verification
The bench fills the return stack to 29 and 30 entries and pushes past that. A design with an off-by-one warning threshold or an overwritten top would show the wrong stack_warn_irq or ret_top. A flag loop has its exit flag raised exactly two cycles, and then one cycle, ahead of the end fetch. A design that tests the undelayed or the one-cycle-delayed flag would exit on the wrong iteration. Nested counted loops check that an inner exit restores the outer end address and counter, and that a call issued during a branch-back cycle does not grow the stack. Opening a seventh loop, or opening a loop onto a full return stack, must leave every depth unchanged while the matching flag rises.

// File: rtl/ctlstk_pkg.sv
package ctlstk_pkg;
  parameter int unsigned ADDR_W = 24;
  parameter int unsigned CNT_W  = 16;
  parameter int unsigned NFLAG  = 8;
  localparam int unsigned FSEL_W = $clog2(NFLAG);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  count_t;

  // per-loop tag kept on the end-address stack
  typedef struct packed {
    logic              by_count;
    logic [FSEL_W-1:0] fsel;
    addr_t             end_addr;
  } loop_tag_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_CALL, OP_RET, OP_LOOP, OP_ABORT
  } cmd_e;

  // loop terminates at its end address under this condition
  function automatic logic loop_done(loop_tag_t t, count_t c,
                                     logic [NFLAG-1:0] late_flags);
    if (t.by_count) return (c <= count_t'(1));
    return late_flags[t.fsel];
  endfunction

  function automatic count_t count_next(count_t c);
    return c - count_t'(1);
  endfunction
endpackage

// File: rtl/cs_lifo.sv
module cs_lifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          upd,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  udata,
  output logic [W-1:0]  top,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [LW-1:0] top_idx;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign top_idx = level - LW'(1);
  assign top     = empty ? '0 : mem[top_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               level <= '0;
    else if (push && !full)   level <= level + LW'(1);
    else if (pop && !empty)   level <= level - LW'(1);
  end

  always_ff @(posedge clk) begin
    if (push && !full)                mem[level]   <= wdata;
    else if (upd && !pop && !empty)   mem[top_idx] <= udata;
  end
endmodule

// File: rtl/cs_loop_ctl.sv
module cs_loop_ctl
  import ctlstk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  addr_t            fetch_addr,
  input  logic [NFLAG-1:0] cond_flags,
  input  logic             have_loop,
  input  loop_tag_t        tag_top,
  input  count_t           cnt_top,
  input  addr_t            start_addr,
  output logic             jump_back,
  output logic             loop_exit,
  output addr_t            jump_target,
  output count_t           cnt_after
);
  logic [NFLAG-1:0] flags_d1, flags_d2;
  logic at_end, finish;

  // exit test sees flags from two cycles earlier
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_d1 <= '0;
      flags_d2 <= '0;
    end else begin
      flags_d1 <= cond_flags;
      flags_d2 <= flags_d1;
    end
  end

  assign at_end      = fetch_valid && have_loop && (fetch_addr == tag_top.end_addr);
  assign finish      = loop_done(tag_top, cnt_top, flags_d2);
  assign jump_back   = at_end && !finish;
  assign loop_exit   = at_end && finish;
  assign jump_target = start_addr;
  assign cnt_after   = count_next(cnt_top);
endmodule

// File: rtl/cs_cmd_arb.sv
module cs_cmd_arb
  import ctlstk_pkg::*;
(
  input  logic busy,
  input  logic call_req,
  input  logic ret_req,
  input  logic loop_req,
  input  logic loop_abort,
  output cmd_e op
);
  always_comb begin
    op = OP_NONE;
    if (!busy) begin
      if (call_req)        op = OP_CALL;
      else if (ret_req)    op = OP_RET;
      else if (loop_req)   op = OP_LOOP;
      else if (loop_abort) op = OP_ABORT;
    end
  end
endmodule

// File: rtl/ctlstk_unit.sv
module ctlstk_unit
  import ctlstk_pkg::*;
#(
  parameter int unsigned RET_DEPTH  = 30,
  parameter int unsigned WARN_LEVEL = 29,
  parameter int unsigned LOOP_DEPTH = 6,
  localparam int unsigned RDW = $clog2(RET_DEPTH + 1),
  localparam int unsigned LDW = $clog2(LOOP_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_req,
  input  logic [ADDR_W-1:0] call_addr,
  input  logic              ret_req,
  input  logic              loop_req,
  input  logic [ADDR_W-1:0] loop_start,
  input  logic [ADDR_W-1:0] loop_end,
  input  logic [CNT_W-1:0]  loop_count,
  input  logic              loop_by_count,
  input  logic [FSEL_W-1:0] loop_flag_sel,
  input  logic              loop_abort,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [NFLAG-1:0]  cond_flags,
  input  logic              clear_sticky,
  output logic              jump_back,
  output logic [ADDR_W-1:0] jump_target,
  output logic              loop_exit,
  output logic [ADDR_W-1:0] ret_top,
  output logic [RDW-1:0]    ret_depth,
  output logic [CNT_W-1:0]  cnt_top,
  output logic [ADDR_W-1:0] end_top,
  output logic [LDW-1:0]    loop_depth,
  output logic              stack_warn_irq,
  output logic              ret_overflow,
  output logic              ret_underflow,
  output logic              loop_overflow,
  output logic              loop_underflow
);
  localparam int unsigned TAG_W = $bits(loop_tag_t);

  cmd_e      op;
  logic      busy;
  logic      ret_full, ret_empty, ret_push, ret_pop;
  addr_t     ret_wdata;
  logic      cnt_full, cnt_empty, tag_full, tag_empty;
  logic      lp_full, lp_empty, lp_push, lp_pop, cnt_upd, loop_ok;
  logic [LDW-1:0] lvl_cnt, lvl_tag;
  loop_tag_t tag_top, tag_new;
  count_t    cnt_after;
  // named events for the checker
  logic      ev_ret_ovf, ev_ret_unf, ev_lp_ovf, ev_lp_unf;

  assign busy = jump_back | loop_exit;

  cs_cmd_arb u_arb (
    .busy(busy), .call_req(call_req), .ret_req(ret_req),
    .loop_req(loop_req), .loop_abort(loop_abort), .op(op)
  );

  assign lp_full   = cnt_full | tag_full;
  assign lp_empty  = cnt_empty | tag_empty;
  assign loop_ok   = (op == OP_LOOP) && !ret_full && !lp_full;
  assign ret_push  = ((op == OP_CALL) && !ret_full) || loop_ok;
  assign ret_wdata = (op == OP_CALL) ? call_addr : loop_start;
  assign ret_pop   = (op == OP_RET) || loop_exit;
  assign lp_push   = loop_ok;
  assign lp_pop    = (op == OP_ABORT) || loop_exit;
  assign cnt_upd   = jump_back && tag_top.by_count;
  assign tag_new   = '{by_count: loop_by_count, fsel: loop_flag_sel, end_addr: loop_end};

  assign ev_ret_ovf = ((op == OP_CALL) || (op == OP_LOOP)) && ret_full;
  assign ev_ret_unf = ret_pop && ret_empty;
  assign ev_lp_ovf  = (op == OP_LOOP) && lp_full;
  assign ev_lp_unf  = (op == OP_ABORT) && lp_empty;

  cs_lifo #(.W(ADDR_W), .DEPTH(RET_DEPTH)) u_ret (
    .clk(clk), .rst_n(rst_n), .push(ret_push), .pop(ret_pop), .upd(1'b0),
    .wdata(ret_wdata), .udata('0), .top(ret_top), .level(ret_depth),
    .full(ret_full), .empty(ret_empty)
  );

  cs_lifo #(.W(CNT_W), .DEPTH(LOOP_DEPTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .push(lp_push), .pop(lp_pop), .upd(cnt_upd),
    .wdata(loop_count), .udata(cnt_after), .top(cnt_top), .level(lvl_cnt),
    .full(cnt_full), .empty(cnt_empty)
  );

  cs_lifo #(.W(TAG_W), .DEPTH(LOOP_DEPTH)) u_tag (
    .clk(clk), .rst_n(rst_n), .push(lp_push), .pop(lp_pop), .upd(1'b0),
    .wdata(tag_new), .udata('0), .top(tag_top), .level(lvl_tag),
    .full(tag_full), .empty(tag_empty)
  );

  cs_loop_ctl u_loop (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .cond_flags(cond_flags), .have_loop(!lp_empty), .tag_top(tag_top),
    .cnt_top(cnt_top), .start_addr(ret_top), .jump_back(jump_back),
    .loop_exit(loop_exit), .jump_target(jump_target), .cnt_after(cnt_after)
  );

  assign loop_depth     = lvl_cnt;
  assign end_top        = tag_top.end_addr;
  assign stack_warn_irq = (ret_depth >= RDW'(WARN_LEVEL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_overflow   <= 1'b0;
      ret_underflow  <= 1'b0;
      loop_overflow  <= 1'b0;
      loop_underflow <= 1'b0;
    end else begin
      ret_overflow   <= (ret_overflow   & ~clear_sticky) | ev_ret_ovf;
      ret_underflow  <= (ret_underflow  & ~clear_sticky) | ev_ret_unf;
      loop_overflow  <= (loop_overflow  & ~clear_sticky) | ev_lp_ovf;
      loop_underflow <= (loop_underflow & ~clear_sticky) | ev_lp_unf;
    end
  end
endmodule

// File: rtl/ctlstk_unit_chk.sv
module ctlstk_unit_chk #(
  parameter int unsigned RET_DEPTH  = 30,
  parameter int unsigned WARN_LEVEL = 29,
  parameter int unsigned LOOP_DEPTH = 6,
  localparam int unsigned RDW = $clog2(RET_DEPTH + 1),
  localparam int unsigned LDW = $clog2(LOOP_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           call_req,
  input logic           clear_sticky,
  input logic           jump_back,
  input logic           loop_exit,
  input logic [RDW-1:0] ret_depth,
  input logic [LDW-1:0] loop_depth,
  input logic [LDW-1:0] lvl_cnt,
  input logic [LDW-1:0] lvl_tag,
  input logic           stack_warn_irq,
  input logic           ret_overflow
);
  a_r3_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ret_depth <= RDW'(RET_DEPTH));

  a_r6_loop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    loop_depth <= LDW'(LOOP_DEPTH));

  a_r6_levels_agree: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_cnt == lvl_tag);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(jump_back && loop_exit));

  a_r7_depth_hold: assert property (@(posedge clk) disable iff (!rst_n)
    jump_back |=> $stable(ret_depth) && $stable(loop_depth));

  a_r8_exit_pops: assert property (@(posedge clk) disable iff (!rst_n)
    loop_exit |=> loop_depth == $past(loop_depth) - LDW'(1));

  a_r4_warn_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stack_warn_irq) |-> ret_depth == RDW'(WARN_LEVEL));

  a_r4_warn_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stack_warn_irq) |-> ret_depth == RDW'(WARN_LEVEL - 1));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_overflow && !clear_sticky) |=> ret_overflow);

  a_r11_call_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_back && call_req) |=> $stable(ret_depth));
endmodule

bind ctlstk_unit ctlstk_unit_chk #(
  .RET_DEPTH(RET_DEPTH), .WARN_LEVEL(WARN_LEVEL), .LOOP_DEPTH(LOOP_DEPTH)
) u_chk (.*);

// File: tb/ctlstk_unit_test.sv
`timescale 1ns/1ps
module ctlstk_unit_test;
  import ctlstk_pkg::*;

  localparam int RD = 30;
  localparam int LD = 6;
  localparam int WL = 29;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rst_n;
  logic call_req, ret_req, loop_req, loop_by_count, loop_abort;
  logic fetch_valid, clear_sticky;
  addr_t call_addr, loop_start, loop_end, fetch_addr;
  count_t loop_count;
  logic [FSEL_W-1:0] loop_flag_sel;
  logic [NFLAG-1:0] cond_flags;

  logic jump_back, loop_exit, stack_warn_irq;
  logic ret_overflow, ret_underflow, loop_overflow, loop_underflow;
  addr_t jump_target, ret_top, end_top;
  count_t cnt_top;
  logic [4:0] ret_depth;
  logic [2:0] loop_depth;

  ctlstk_unit uut (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_addr(call_addr),
    .ret_req(ret_req), .loop_req(loop_req), .loop_start(loop_start),
    .loop_end(loop_end), .loop_count(loop_count), .loop_by_count(loop_by_count),
    .loop_flag_sel(loop_flag_sel), .loop_abort(loop_abort),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .cond_flags(cond_flags),
    .clear_sticky(clear_sticky), .jump_back(jump_back), .jump_target(jump_target),
    .loop_exit(loop_exit), .ret_top(ret_top), .ret_depth(ret_depth),
    .cnt_top(cnt_top), .end_top(end_top), .loop_depth(loop_depth),
    .stack_warn_irq(stack_warn_irq), .ret_overflow(ret_overflow),
    .ret_underflow(ret_underflow), .loop_overflow(loop_overflow),
    .loop_underflow(loop_underflow)
  );

  typedef struct {
    logic call; addr_t cadr; logic ret;
    logic lreq; addr_t ls; addr_t le; count_t lc; logic lbc; logic [FSEL_W-1:0] lsel;
    logic abort; logic fv; addr_t fa; logic [NFLAG-1:0] fl; logic clr;
  } stim_t;

  typedef struct {
    string tag;
    logic jb; logic lx; addr_t tgt;
    int rd; int ld; addr_t rt; count_t ct; addr_t et; logic irq; logic [3:0] st;
  } exp_t;

  exp_t q[$];
  int n_tests = 0;
  int n_fail  = 0;

  // reference stacks
  addr_t  m_ret[$];
  count_t m_cnt[$];
  addr_t  m_end[$];
  logic   m_bc[$];
  logic [FSEL_W-1:0] m_sel[$];
  logic [NFLAG-1:0] m_d1 = '0, m_d2 = '0;
  logic [3:0] m_st = '0;  // {loop_unf, loop_ovf, ret_unf, ret_ovf}

  function automatic stim_t idle();
    stim_t s;
    s = '{default: '0};
    return s;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input stim_t s, input string tag);
    exp_t e;
    logic match, term;
    int lt, rt;
    @(negedge clk);
    call_req = s.call; call_addr = s.cadr; ret_req = s.ret;
    loop_req = s.lreq; loop_start = s.ls; loop_end = s.le; loop_count = s.lc;
    loop_by_count = s.lbc; loop_flag_sel = s.lsel; loop_abort = s.abort;
    fetch_valid = s.fv; fetch_addr = s.fa; cond_flags = s.fl; clear_sticky = s.clr;
    lt = m_end.size() - 1;
    match = s.fv && (m_end.size() > 0) && (s.fa == m_end[(lt < 0) ? 0 : lt]);
    term = 1'b0;
    if (match) term = m_bc[lt] ? (m_cnt[lt] <= 1) : m_d2[m_sel[lt]];
    e.jb  = match && !term;
    e.lx  = match && term;
    e.tgt = (m_ret.size() > 0) ? m_ret[m_ret.size()-1] : '0;
    e.tag = tag;
    if (s.clr) m_st = '0;
    if (e.jb) begin
      if (m_bc[lt]) m_cnt[lt] = m_cnt[lt] - 1;
    end else if (e.lx) begin
      void'(m_cnt.pop_back()); void'(m_end.pop_back());
      void'(m_bc.pop_back());  void'(m_sel.pop_back());
      if (m_ret.size() > 0) void'(m_ret.pop_back()); else m_st[1] = 1'b1;
    end else if (s.call) begin
      if (m_ret.size() == RD) m_st[0] = 1'b1; else m_ret.push_back(s.cadr);
    end else if (s.ret) begin
      if (m_ret.size() == 0) m_st[1] = 1'b1; else void'(m_ret.pop_back());
    end else if (s.lreq) begin
      if (m_ret.size() == RD) m_st[0] = 1'b1;
      if (m_end.size() == LD) m_st[2] = 1'b1;
      if (m_ret.size() < RD && m_end.size() < LD) begin
        m_ret.push_back(s.ls); m_cnt.push_back(s.lc); m_end.push_back(s.le);
        m_bc.push_back(s.lbc); m_sel.push_back(s.lsel);
      end
    end else if (s.abort) begin
      if (m_end.size() == 0) m_st[3] = 1'b1;
      else begin
        void'(m_cnt.pop_back()); void'(m_end.pop_back());
        void'(m_bc.pop_back());  void'(m_sel.pop_back());
      end
    end
    m_d2 = m_d1;
    m_d1 = s.fl;
    rt = m_ret.size();
    lt = m_end.size();
    e.rd  = rt;
    e.ld  = lt;
    e.rt  = (rt > 0) ? m_ret[rt-1] : '0;
    e.ct  = (lt > 0) ? m_cnt[lt-1] : '0;
    e.et  = (lt > 0) ? m_end[lt-1] : '0;
    e.irq = (rt >= WL);
    e.st  = m_st;
    q.push_back(e);
  endtask

  // monitor: combinational outputs before the edge, state after it
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, "jump_back", 64'(jump_back), 64'(e.jb));
        chk(e.tag, "loop_exit", 64'(loop_exit), 64'(e.lx));
        if (e.jb) chk(e.tag, "jump_target", 64'(jump_target), 64'(e.tgt));
        @(posedge clk);
        #1;
        chk(e.tag, "ret_depth", 64'(ret_depth), 64'(e.rd));
        chk(e.tag, "loop_depth", 64'(loop_depth), 64'(e.ld));
        chk(e.tag, "ret_top", 64'(ret_top), 64'(e.rt));
        chk(e.tag, "cnt_top", 64'(cnt_top), 64'(e.ct));
        chk(e.tag, "end_top", 64'(end_top), 64'(e.et));
        chk(e.tag, "stack_warn_irq", 64'(stack_warn_irq), 64'(e.irq));
        chk(e.tag, "sticky", 64'({loop_underflow, loop_overflow, ret_underflow, ret_overflow}),
            64'(e.st));
      end
    end
  end

  task automatic do_call(addr_t a, string tag);
    stim_t s = idle(); s.call = 1'b1; s.cadr = a; step(s, tag);
  endtask
  task automatic do_ret(string tag);
    stim_t s = idle(); s.ret = 1'b1; step(s, tag);
  endtask
  task automatic do_loop(addr_t st, addr_t en, count_t c, logic bc,
                         logic [FSEL_W-1:0] sel, string tag);
    stim_t s = idle();
    s.lreq = 1'b1; s.ls = st; s.le = en; s.lc = c; s.lbc = bc; s.lsel = sel;
    step(s, tag);
  endtask
  task automatic do_abort(string tag);
    stim_t s = idle(); s.abort = 1'b1; step(s, tag);
  endtask
  task automatic do_fetch(addr_t a, string tag);
    stim_t s = idle(); s.fv = 1'b1; s.fa = a; step(s, tag);
  endtask
  task automatic do_idle(string tag);
    step(idle(), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    stim_t s;
    rst_n = 1'b0;
    call_req = 0; ret_req = 0; loop_req = 0; loop_by_count = 0; loop_abort = 0;
    fetch_valid = 0; clear_sticky = 0; call_addr = '0; loop_start = '0;
    loop_end = '0; fetch_addr = '0; loop_count = '0; loop_flag_sel = '0; cond_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    do_idle("R1 reset");

    // R2/R4/R3: fill the return stack and push past it
    for (int i = 0; i < 28; i++) do_call(addr_t'(24'h100 + i), "R2 push");
    do_call(24'h1AA, "R4 warn at 29");
    do_call(24'h1BB, "R3 fill 30");
    do_call(24'h1CC, "R3 overflow");
    do_idle("R10 held");
    for (int i = 0; i < 31; i++) do_ret("R2 pop / R3 underflow");
    s = idle(); s.clr = 1'b1; s.ret = 1'b1; step(s, "R10 set wins over clear");
    s = idle(); s.clr = 1'b1; step(s, "R10 clear");

    // R7/R8: counted loop, 3 iterations
    do_loop(24'h200, 24'h203, 16'd3, 1'b1, 3'd0, "R5 open");
    for (int it = 0; it < 3; it++)
      for (int a = 0; a < 4; a++) do_fetch(addr_t'(24'h200 + a), "R7 R8 body");
    do_fetch(24'h203, "R8 no loop open");

    // R9: flag loop with two-cycle delayed test
    do_loop(24'h300, 24'h301, 16'd0, 1'b0, 3'd5, "R9 open");
    do_fetch(24'h300, "R9");
    do_fetch(24'h301, "R9 flag low");
    s = idle(); s.fl = 8'h20; step(s, "R9 raise flag");
    do_fetch(24'h301, "R9 one cycle late no exit");
    do_fetch(24'h301, "R9 two cycles exit");

    // R12/R11: nested counted loops
    do_loop(24'h400, 24'h420, 16'd2, 1'b1, 3'd0, "R12 outer");
    do_loop(24'h408, 24'h410, 16'd2, 1'b1, 3'd0, "R12 inner");
    s = idle(); s.fv = 1'b1; s.fa = 24'h410; s.call = 1'b1; s.cadr = 24'h999;
    step(s, "R11 call ignored on branch back");
    do_fetch(24'h410, "R12 inner exit");
    s = idle(); s.call = 1'b1; s.cadr = 24'h555; s.ret = 1'b1; s.lreq = 1'b1;
    step(s, "R11 call wins");
    s = idle(); s.ret = 1'b1; s.abort = 1'b1; step(s, "R11 ret over abort");
    do_fetch(24'h420, "R12 outer back");
    do_fetch(24'h420, "R12 outer exit");

    // R5/R6: loop stacks full, abort pops loop stacks only
    for (int i = 0; i < 7; i++)
      do_loop(addr_t'(24'h500 + i), addr_t'(24'h600 + i), 16'd4, 1'b0, 3'd1, "R6 fill / overflow");
    for (int i = 0; i < 7; i++) do_abort("R6 abort / underflow");
    for (int i = 0; i < 6; i++) do_ret("R6 return stack kept");
    s = idle(); s.clr = 1'b1; step(s, "R10 clear");

    // R5: loop refused when return stack is full
    for (int i = 0; i < 30; i++) do_call(addr_t'(24'h700 + i), "R5 fill");
    do_loop(24'h800, 24'h810, 16'd2, 1'b1, 3'd0, "R5 refused");
    for (int i = 0; i < 30; i++) do_ret("R5 drain");
    do_idle("R1 idle");

    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule